// File: doc/BRIEF.md
# Dual-Channel High/Low Count Pulse Generator

Two independent pulse-width outputs, set up through a small word-addressed register port. Each channel has a count word that holds a high-phase length and a low-phase length, both measured in ticks. A shared control word holds the per-channel tick setup and enables. A tick lasts (prescaler + 1) pulses of one of four source strobes. The strobes are tick-enable inputs in the block's own clock domain. Each enabled output is high for the high length, then low for the low length, and the period repeats.

The block has no polarity control. Software gets an inverted waveform by swapping the two lengths. A low length of zero still gives a low phase of one tick. With the high length at its maximum this is the closest the block gets to a constant high level. Length changes made while a channel runs take effect only at the next period start, so a period is never cut or stretched by a write. Clearing a channel's output enable drops that output at once.

Top module: `pwmhl_top`

## Requirements
- R1: After reset every register reads zero and both outputs are low.
- R2: Each register reads back the last value written to it. Word offsets: channel A counts at 0x0, channel B counts at 0x4, control at 0x8.
- R3: In a count word, bits 31:16 are the high length and bits 15:0 the low length. In the control word, bit 0 and bit 1 are the output enables of A and B. Bits 5:4 and 7:6 are their source selects. Bits 14:8 and 22:16 are their prescalers. Bit 15 and bit 23 are their clock enables.
- R4: A source select value n picks source strobe n. One tick spans (prescaler + 1) pulses of that strobe.
- R5: While running, a channel repeats a period of H ticks high followed by L ticks low.
- R6: A low length of zero yields a low phase of one tick. With H = 0xFFFF and L = 0 the output is low for one tick per period.
- R7: A high length of zero keeps the output low.
- R8: A channel runs only when both its clock enable and its output enable are set. Otherwise its output is low.
- R9: Clearing the output enable forces the output low in the cycle after the write, even in mid-phase.
- R10: A count word written while the channel runs is used from the next period start on. The current period finishes with the old lengths.
- R11: The two channels run independently with different sources, prescalers and lengths.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | Write when set together with bus_sel |
| bus_addr | input | 4 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data of the addressed register (combinational) |
| src_tick | input | 4 | Tick-enable strobes of the four clock sources |
| pwm_out | output | 2 | Pulse outputs, bit 0 channel A, bit 1 channel B |

## Verification
The bench builds the block with its default parameters: 16-bit lengths, 7-bit prescalers, 2-bit source selects and two channels. With 16-bit lengths, the full-length case (0xFFFF high, zero low) fits in roughly 65 thousand cycles, so the one-tick low pulse at the far end of the range is measured directly. The four sources are driven as strobes that fire every cycle, every second, every fourth and every third cycle. With these, every select value and several prescaler settings produce distinct pulse widths.

// File: rtl/pwmhl_pkg.sv
package pwmhl_pkg;
  parameter int CNT_W  = 16;
  parameter int PRE_W  = 7;
  parameter int SEL_W  = 2;
  parameter int CH_N   = 2;
  parameter int DATA_W = 32;
  parameter int ADDR_W = 4;
endpackage

// File: rtl/pwmhl_regs.sv
module pwmhl_regs #(
  parameter int CH_N   = 2,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       bus_sel,
  input  logic                       bus_wr,
  input  logic [ADDR_W-1:0]          bus_addr,
  input  logic [DATA_W-1:0]          bus_wdata,
  output logic [DATA_W-1:0]          bus_rdata,
  output logic [CH_N-1:0][DATA_W-1:0] cnt_q,
  output logic [DATA_W-1:0]          ctrl_q
);
  localparam int IDX_W = ADDR_W - 2;

  logic [IDX_W-1:0]           idx;
  logic [CH_N-1:0][DATA_W-1:0] cnt_n;
  logic [DATA_W-1:0]          ctrl_n;
  logic                       wr_en;

  assign idx   = bus_addr[ADDR_W-1:2];
  assign wr_en = bus_sel & bus_wr;

  always_comb begin
    cnt_n  = cnt_q;
    ctrl_n = ctrl_q;
    if (wr_en) begin
      for (int i = 0; i < CH_N; i++)
        if (idx == IDX_W'(i)) cnt_n[i] = bus_wdata;
      if (idx == IDX_W'(CH_N)) ctrl_n = bus_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      ctrl_q <= '0;
    end else if (wr_en) begin
      cnt_q  <= cnt_n;
      ctrl_q <= ctrl_n;
    end
  end

  always_comb begin
    bus_rdata = '0;
    for (int i = 0; i < CH_N; i++)
      if (idx == IDX_W'(i)) bus_rdata = cnt_q[i];
    if (idx == IDX_W'(CH_N)) bus_rdata = ctrl_q;
  end

  // R2: a write to the control word is visible on the next cycle
  assert_ctrl_readback_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && idx == IDX_W'(CH_N)) |=> (ctrl_q == $past(bus_wdata)));
endmodule

// File: rtl/pwmhl_chan.sv
module pwmhl_chan #(
  parameter int CNT_W = 16,
  parameter int PRE_W = 7,
  parameter int SEL_W = 2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   run,
  input  logic [(1<<SEL_W)-1:0]  src_tick,
  input  logic [SEL_W-1:0]       src_sel,
  input  logic [PRE_W-1:0]       pre_div,
  input  logic [CNT_W-1:0]       hi_len,
  input  logic [CNT_W-1:0]       lo_len,
  output logic                   pwm_o
);
  logic             started_q, started_n;
  logic             hi_q, hi_n;
  logic [CNT_W-1:0] left_q, left_n;
  logic [CNT_W-1:0] cur_lo_q, cur_lo_n;
  logic [PRE_W-1:0] pre_q, pre_n;
  logic             src_hit, tick;

  function automatic logic [CNT_W-1:0] at_least_one(input logic [CNT_W-1:0] v);
    return (v == '0) ? CNT_W'(1) : v;
  endfunction

  assign src_hit = src_tick[src_sel];
  assign tick    = run & started_q & src_hit & (pre_q >= pre_div);

  // prescaler next state
  always_comb begin
    pre_n = pre_q;
    if (!run || !started_q)     pre_n = '0;
    else if (src_hit)           pre_n = (pre_q >= pre_div) ? '0 : pre_q + 1'b1;
  end

  // phase sequencer next state
  always_comb begin
    started_n = started_q;
    hi_n      = hi_q;
    left_n    = left_q;
    cur_lo_n  = cur_lo_q;
    if (!run) begin
      started_n = 1'b0;
      hi_n      = 1'b0;
      left_n    = '0;
      cur_lo_n  = '0;
    end else if (!started_q || (tick && left_q == CNT_W'(1) && !hi_q)) begin
      started_n = 1'b1;
      cur_lo_n  = lo_len;
      if (hi_len != '0) begin
        hi_n   = 1'b1;
        left_n = hi_len;
      end else begin
        hi_n   = 1'b0;
        left_n = at_least_one(lo_len);
      end
    end else if (tick) begin
      if (left_q == CNT_W'(1)) begin
        hi_n   = 1'b0;
        left_n = at_least_one(cur_lo_q);
      end else begin
        left_n = left_q - 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      started_q <= 1'b0;
      hi_q      <= 1'b0;
      left_q    <= '0;
      cur_lo_q  <= '0;
      pre_q     <= '0;
    end else begin
      started_q <= started_n;
      hi_q      <= hi_n;
      left_q    <= left_n;
      cur_lo_q  <= cur_lo_n;
      pre_q     <= pre_n;
    end
  end

  assign pwm_o = run & hi_q;

  // R5: a running phase always has ticks left
  assert_left_live_R5: assert property (@(posedge clk) disable iff (!rst_n)
    started_q |-> (left_q != '0));
  // R4: after a source pulse the prescaler never passes its limit
  assert_pre_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (run && started_q && src_hit) |=> (pre_q <= $past(pre_div)));
  // R7: a period starting with zero high length begins low
  assert_zero_high_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !started_q && hi_len == '0) |=> !hi_q);
  // R10: the latched low length only changes at a period start
  assert_latch_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (run && started_q && !(tick && left_q == CNT_W'(1) && !hi_q))
      |=> (!run || $stable(cur_lo_q)));
endmodule

// File: rtl/pwmhl_top.sv
module pwmhl_top
  import pwmhl_pkg::*;
#(
  parameter int P_CNT_W  = CNT_W,
  parameter int P_PRE_W  = PRE_W,
  parameter int P_SEL_W  = SEL_W,
  parameter int P_CH_N   = CH_N,
  parameter int P_DATA_W = DATA_W,
  parameter int P_ADDR_W = ADDR_W
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      bus_sel,
  input  logic                      bus_wr,
  input  logic [P_ADDR_W-1:0]       bus_addr,
  input  logic [P_DATA_W-1:0]       bus_wdata,
  output logic [P_DATA_W-1:0]       bus_rdata,
  input  logic [(1<<P_SEL_W)-1:0]   src_tick,
  output logic [P_CH_N-1:0]         pwm_out
);
  localparam int SRC_N = 1 << P_SEL_W;
  localparam int SEL_LSB = 4;
  localparam int PRE_LSB = 8;
  localparam int CFG_STRIDE = 8;
  localparam int CEN_LSB = PRE_LSB + P_PRE_W;

  logic [1:0] rst_sync_q;
  logic       rst_s_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_s_n = rst_sync_q[1];

  logic [P_CH_N-1:0][P_DATA_W-1:0] cnt_q;
  logic [P_DATA_W-1:0]             ctrl_q;

  pwmhl_regs #(.CH_N(P_CH_N), .DATA_W(P_DATA_W), .ADDR_W(P_ADDR_W)) u_regs (
    .clk       (clk),
    .rst_n     (rst_s_n),
    .bus_sel   (bus_sel),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .cnt_q     (cnt_q),
    .ctrl_q    (ctrl_q)
  );

  for (genvar g = 0; g < P_CH_N; g++) begin : g_chan
    logic                 clk_en, out_en, run;
    logic [P_SEL_W-1:0]   sel;
    logic [P_PRE_W-1:0]   pre;

    assign out_en = ctrl_q[g];
    assign sel    = ctrl_q[SEL_LSB + P_SEL_W*g +: P_SEL_W];
    assign pre    = ctrl_q[PRE_LSB + CFG_STRIDE*g +: P_PRE_W];
    assign clk_en = ctrl_q[CEN_LSB + CFG_STRIDE*g];
    assign run    = clk_en & out_en;

    pwmhl_chan #(.CNT_W(P_CNT_W), .PRE_W(P_PRE_W), .SEL_W(P_SEL_W)) u_chan (
      .clk      (clk),
      .rst_n    (rst_s_n),
      .run      (run),
      .src_tick (src_tick[SRC_N-1:0]),
      .src_sel  (sel),
      .pre_div  (pre),
      .hi_len   (cnt_q[g][2*P_CNT_W-1:P_CNT_W]),
      .lo_len   (cnt_q[g][P_CNT_W-1:0]),
      .pwm_o    (pwm_out[g])
    );

    // R8: a channel missing either enable keeps its output low
    assert_gated_low_R8: assert property (@(posedge clk) disable iff (!rst_s_n)
      !(clk_en && out_en) |-> !pwm_out[g]);
  end
endmodule

// File: tb/sim_pwmhl_top.sv
module sim_pwmhl_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_sel, bus_wr;
  logic [3:0]  bus_addr;
  logic [31:0] bus_wdata, bus_rdata;
  logic [3:0]  src_tick;
  logic [1:0]  pwm_out;

  always #10 clk = ~clk;

  pwmhl_top u0 (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .src_tick(src_tick), .pwm_out(pwm_out)
  );

  // source strobes: every cycle, every 2nd, every 4th, every 3rd
  int tcnt = 0;
  always @(posedge clk) tcnt <= tcnt + 1;
  assign src_tick = {(tcnt % 3) == 0, (tcnt % 4) == 0, (tcnt % 2) == 0, 1'b1};

  // pulse-width recorder, sampled on the falling edge
  int   rise_cnt [2];
  int   hi_done  [2];
  int   last_hi  [2];
  int   last_lo  [2];
  int   run_len  [2];
  logic prev     [2];
  initial for (int c = 0; c < 2; c++) begin
    rise_cnt[c] = 0; hi_done[c] = 0; last_hi[c] = 0; last_lo[c] = 0;
    run_len[c] = 0; prev[c] = 1'b0;
  end
  always @(negedge clk) begin
    for (int c = 0; c < 2; c++) begin
      if (pwm_out[c] !== prev[c]) begin
        if (pwm_out[c] === 1'b1) begin
          rise_cnt[c] = rise_cnt[c] + 1;
          last_lo[c]  = run_len[c];
        end else begin
          hi_done[c] = hi_done[c] + 1;
          last_hi[c] = run_len[c];
        end
        run_len[c] = 0;
      end
      run_len[c] = run_len[c] + 1;
      prev[c]    = pwm_out[c];
    end
  end

  int checks = 0;
  int fails  = 0;
  logic [31:0] ctrl_sh = '0;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic set_ch(input int c, input int sel, input int pre, input bit ce, input bit oe);
    ctrl_sh[c]              = oe;
    ctrl_sh[4 + 2*c +: 2]   = sel[1:0];
    ctrl_sh[8 + 8*c +: 7]   = pre[6:0];
    ctrl_sh[15 + 8*c]       = ce;
    wr(4'h8, ctrl_sh);
  endtask

  task automatic set_len(input int c, input int hi, input int lo);
    wr(4'(4*c), {hi[15:0], lo[15:0]});
  endtask

  task automatic wait_hi(input int c, input int n);
    int target = hi_done[c] + n;
    while (hi_done[c] < target) @(negedge clk);
  endtask

  task automatic wait_rise(input int c);
    int target = rise_cnt[c] + 1;
    while (rise_cnt[c] < target) @(negedge clk);
  endtask

  task automatic summary;
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
  endtask

  // columns: select, prescaler, high len, low len, exp high cycles, exp low cycles
  localparam int VEC [7][6] = '{
    '{0, 0, 3, 2,  3, 2},
    '{0, 2, 4, 1, 12, 3},
    '{0, 0, 5, 0,  5, 1},
    '{1, 0, 2, 3,  4, 6},
    '{2, 1, 1, 1,  8, 8},
    '{3, 0, 2, 2,  6, 6},
    '{3, 1, 2, 1, 12, 6}
  };

  initial begin
    repeat (195000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual %0d expected %0d", 195000, 0);
    summary();
    $finish;
  end

  initial begin
    logic [31:0] d;
    int r;
    bus_sel = 0; bus_wr = 0; bus_addr = '0; bus_wdata = '0;
    rst_n = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1: reset state
    rd(4'h0, d); chk("R1 count A", int'(d), 0);
    rd(4'h4, d); chk("R1 count B", int'(d), 0);
    rd(4'h8, d); chk("R1 control", int'(d), 0);
    chk("R1 outputs", int'(pwm_out), 0);

    // R2: readback (outputs stay off: out enables clear)
    wr(4'h0, 32'h1234ABCD); rd(4'h0, d); chk("R2 count A", int'(d), int'(32'h1234ABCD));
    wr(4'h4, 32'h80000001); rd(4'h4, d); chk("R2 count B", int'(d), int'(32'h80000001));
    wr(4'h8, 32'h00FFFF00); rd(4'h8, d); chk("R2 control", int'(d), int'(32'h00FFFF00));
    wr(4'h8, 32'h0); ctrl_sh = '0;

    // R3 R4 R5 R6: vector table, alternating channels
    for (int v = 0; v < 7; v++) begin
      int c = v % 2;
      set_ch(c, 0, 0, 1'b0, 1'b0);
      set_len(c, VEC[v][2], VEC[v][3]);
      set_ch(c, VEC[v][0], VEC[v][1], 1'b1, 1'b1);
      wait_hi(c, 3);
      chk($sformatf("R5 R4 R3 vec%0d high", v), last_hi[c], VEC[v][4]);
      chk($sformatf("R5 R6 R3 vec%0d low", v), last_lo[c], VEC[v][5]);
      set_ch(c, 0, 0, 1'b0, 1'b0);
    end

    // R11: both channels at once
    set_len(0, 3, 2); set_len(1, 2, 2);
    set_ch(0, 0, 0, 1'b1, 1'b1); set_ch(1, 3, 0, 1'b1, 1'b1);
    wait_hi(0, 3); wait_hi(1, 3);
    chk("R11 A high", last_hi[0], 3); chk("R11 A low", last_lo[0], 2);
    chk("R11 B high", last_hi[1], 6); chk("R11 B low", last_lo[1], 6);
    set_ch(1, 0, 0, 1'b0, 1'b0);

    // R9: immediate stop in mid-high
    set_ch(0, 0, 0, 1'b0, 1'b0);
    set_len(0, 10, 10);
    set_ch(0, 0, 0, 1'b1, 1'b1);
    wait_rise(0);
    repeat (2) @(negedge clk);
    set_ch(0, 0, 0, 1'b1, 1'b0);
    chk("R9 stop at once", int'(pwm_out[0]), 0);

    // R8: clock enable alone keeps the output low
    r = rise_cnt[0];
    repeat (30) @(negedge clk);
    chk("R8 clk enable only", rise_cnt[0] - r, 0);
    set_ch(0, 0, 0, 1'b0, 1'b1);
    repeat (30) @(negedge clk);
    chk("R8 out enable only", rise_cnt[0] - r, 0);
    set_ch(0, 0, 0, 1'b0, 1'b0);

    // R10: new lengths apply at the next period
    set_len(0, 10, 10);
    set_ch(0, 0, 0, 1'b1, 1'b1);
    wait_rise(0);
    set_len(0, 3, 4);
    wait_hi(0, 1); chk("R10 current high", last_hi[0], 10);
    wait_hi(0, 1); chk("R10 current low", last_lo[0], 10);
                   chk("R10 next high", last_hi[0], 3);
    wait_hi(0, 1); chk("R10 next low", last_lo[0], 4);
    set_ch(0, 0, 0, 1'b0, 1'b0);

    // R7: zero high length
    set_len(0, 0, 3);
    r = rise_cnt[0];
    set_ch(0, 0, 0, 1'b1, 1'b1);
    repeat (40) @(negedge clk);
    chk("R7 no high phase", rise_cnt[0] - r, 0);
    set_ch(0, 0, 0, 1'b0, 1'b0);

    // R6: full high length, zero low length
    set_len(0, 16'hFFFF, 0);
    set_ch(0, 0, 0, 1'b1, 1'b1);
    wait_rise(0);
    wait_hi(0, 1); chk("R6 full high", last_hi[0], 65535);
    wait_rise(0);  chk("R6 one tick low", last_lo[0], 1);
    set_ch(0, 0, 0, 1'b0, 1'b0);

    summary();
    $finish;
  end
endmodule